// File: doc/BRIEF.md
# Multidrop Register Access Slave

This block is the drive-side responder on a shared control bus. Several drives hang on the same bus. A controller picks one of them with a 3-bit drive select and picks a register with a 5-bit register select. It sets a direction line and raises a demand line. The addressed drive completes a four-phase handshake on a transfer line. On a write it latches the control-line data. On a read it drives the selected register back onto the control lines.

The block holds a small bank of 16-bit registers:

- a function register holding a 5-bit function code and a GO bit;
- a read-only status word;
- a read-only error word;
- a read/write maintenance word;
- one lane of a bus-wide attention summary.

The summary lane is special. Every drive answers when it is selected, whatever the drive select says. Each drive drives only the bit at its own index. Writing a 1 to that lane clears the drive's attention flag.

The block also catches protocol and usage faults and reports them on its error vector:

- accesses to registers that do not exist;
- writes attempted while an operation is running;
- unsupported function codes;
- bad odd parity on written data.

An external motion engine reads the GO bit and function code. It pulses `op_done` when the operation finishes.

The handshake controller has three states:

- **IDLE**: waits for the demand line. The transition *start* (demand high and this drive selected) goes to SETTLE.
- **SETTLE**: gives the bus one cycle to settle. The transition *commit* (demand still high) performs the access and goes to XFER. The transition *abort* (demand already low) returns to IDLE with no register touched.
- **XFER**: holds the transfer line high. The transition *release* (demand low) returns to IDLE.

Top module: `mdrop_reg_slave`

## Requirements
- R1: A selected access raises `bus_xfer` exactly two clock edges after `bus_dem` is first seen high. For a write, the addressed register holds the new value by that same edge.
- R2: On a read, for the whole time `bus_xfer` is high, `bus_doe` is all ones and `bus_dout` carries the addressed register. On a write, `bus_doe` stays zero.
- R3: `bus_xfer` stays high while `bus_dem` stays high, and falls on the first edge after `bus_dem` falls. If `bus_dem` falls during the settle cycle, the access is abandoned: no transfer and no register change.
- R4: For any register other than the attention summary (address 4), a drive select that differs from `DRIVE_ID` produces no transfer and no state change.
- R5: An access to any address from 5 to 31 sets error bit 1. A read of such an address returns all zeros.
- R6: While GO is set, a write to the function (0), status (1) or error (2) register is refused and sets error bit 2. Writes to the maintenance (3) and attention-summary (4) registers still take effect.
- R7: In a function-register write, bits 5:1 are the function code and bit 0 is GO. Writing GO=1 with a code outside {0,1,3,4,8,10,11,12,13,20,23,24,28,31} sets error bit 0 and leaves GO clear. A legal code sets GO.
- R8: Reading address 4 works with any drive select. It enables only bit `DRIVE_ID` of `bus_doe`, and that bit carries the attention flag. Bits 8 to 15 are never driven.
- R9: Writing address 4 with bit `DRIVE_ID` equal to 1 clears attention, and 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R10: A write whose 16 data bits plus `bus_par` hold an even number of ones sets error bit 3 and is discarded.
- R11: `op_done` clears GO and sets attention. Any newly set error bit while GO is clear also sets attention.
- R12: A write to the error register (address 2) with good parity and GO clear clears all error bits.
- R13: Reset leaves GO, attention, error, maintenance, transfer and output enables at zero. The function register reads as bit 11 = 1, bits 5:1 = function and bit 0 = GO. The status register reads as bit 15 = attention, bit 14 = any error, bit 13 = GO and bit 7 = not GO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_dsel | input | 3 | Drive select |
| bus_rsel | input | 5 | Register select |
| bus_wr | input | 1 | Direction: 1 = controller writes |
| bus_dem | input | 1 | Demand from controller |
| bus_din | input | 16 | Control-line data from controller |
| bus_par | input | 1 | Odd-parity bit for bus_din |
| bus_dout | output | 16 | Read data toward controller |
| bus_doe | output | 16 | Per-bit drive enable for bus_dout |
| bus_xfer | output | 1 | Transfer acknowledge |
| op_done | input | 1 | Pulse from motion engine: operation finished |
| go | output | 1 | GO bit toward motion engine |
| func | output | 5 | Function code toward motion engine |
| attn | output | 1 | Attention flag |
| err_flags | output | 16 | Error vector (bits 0..3 used) |

## Verification
The bench builds the block with `DRIVE_ID` set to 5 and the default legal-function mask. With an id in the middle of the 8-bit summary lane, a lane that is shifted by one, or that leaks onto its neighbours, shows up in `bus_doe`. Random drive selects over all eight values make mismatching selects common, so R4 and the select-free summary access of R8 are exercised together. Random function codes cover the legal and illegal sets of R7, both while GO is clear and while it is set.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_SETTLE = 2'd1,
        HS_XFER   = 2'd2
    } hs_state_e;

    // register addresses (the summary address is shared by every drive)
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_ERR   = 2;
    localparam int ADDR_MAINT = 3;
    localparam int ADDR_ASUM  = 4;
    localparam int NUM_REGS   = 5;

    // error vector bit positions
    localparam int EB_ILF  = 0;
    localparam int EB_ILR  = 1;
    localparam int EB_RMR  = 2;
    localparam int EB_CPAR = 3;

    // status / control read layout
    localparam int ST_ATTN  = 15;
    localparam int ST_ERR   = 14;
    localparam int ST_BUSY  = 13;
    localparam int ST_READY = 7;
    localparam int CT_AVAIL = 11;

endpackage

// File: rtl/mdrop_hs_fsm.sv
module mdrop_hs_fsm
    import mdrop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dem,
    input  logic hit,
    output logic access,
    output logic xfer
);

    hs_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HS_IDLE:   if (dem && hit) nxt = HS_SETTLE;        // start
            HS_SETTLE: nxt = dem ? HS_XFER : HS_IDLE;           // commit / abort
            HS_XFER:   if (!dem) nxt = HS_IDLE;                 // release
            default:   nxt = HS_IDLE;
        endcase
    end

    always_comb begin
        access = (state == HS_SETTLE) && dem;
        xfer   = (state == HS_XFER);
    end

endmodule

// File: rtl/mdrop_fn_dec.sv
module mdrop_fn_dec #(
    parameter int                      FN_W       = 5,
    parameter logic [(2**FN_W)-1:0]    LEGAL_MASK = '0
) (
    input  logic [FN_W-1:0] fn,
    output logic            legal
);

    assign legal = LEGAL_MASK[fn];

endmodule

// File: rtl/mdrop_regs.sv
module mdrop_regs
    import mdrop_pkg::*;
#(
    parameter int                   DW         = 16,
    parameter int                   RSEL_W     = 5,
    parameter int                   FN_W       = 5,
    parameter int                   DRIVE_ID   = 0,
    parameter logic [(2**FN_W)-1:0] LEGAL_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              is_wr,
    input  logic [RSEL_W-1:0] rsel,
    input  logic [DW-1:0]     wdata,
    input  logic              par_ok,
    input  logic              op_done,
    output logic              go_q,
    output logic [FN_W-1:0]   func_q,
    output logic              attn_q,
    output logic [DW-1:0]     err_q,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     rd_oe
);

    logic [DW-1:0]   maint_q;
    logic [DW-1:0]   lane_mask;
    logic            fn_legal;
    logic            addr_ok, exempt;
    logic            go_n, attn_n, err_clr, as_clr;
    logic [FN_W-1:0] func_n;
    logic [DW-1:0]   maint_n, err_n, new_err, read_val;

    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_lane
            assign lane_mask[g] = (g == DRIVE_ID);
        end
    endgenerate

    mdrop_fn_dec #(.FN_W(FN_W), .LEGAL_MASK(LEGAL_MASK)) u_dec (
        .fn    (wdata[FN_W:1]),
        .legal (fn_legal)
    );

    assign addr_ok = int'(rsel) < NUM_REGS;
    assign exempt  = (int'(rsel) == ADDR_MAINT) || (int'(rsel) == ADDR_ASUM);

    // next-state of the register bank
    always_comb begin
        go_n    = go_q;
        func_n  = func_q;
        maint_n = maint_q;
        err_clr = 1'b0;
        as_clr  = 1'b0;
        new_err = '0;
        if (op_done) go_n = 1'b0;
        if (access) begin
            if (is_wr && !par_ok) new_err[EB_CPAR] = 1'b1;
            if (!addr_ok) begin
                new_err[EB_ILR] = 1'b1;
            end else if (is_wr && par_ok) begin
                if (go_q && !exempt) begin
                    new_err[EB_RMR] = 1'b1;
                end else begin
                    case (int'(rsel))
                        ADDR_CTRL: begin
                            func_n = wdata[FN_W:1];
                            if (wdata[0] && !fn_legal) new_err[EB_ILF] = 1'b1;
                            else                       go_n = wdata[0];
                        end
                        ADDR_ERR:   err_clr = 1'b1;
                        ADDR_MAINT: maint_n = wdata;
                        ADDR_ASUM:  as_clr  = wdata[DRIVE_ID];
                        default:    ;
                    endcase
                end
            end
        end
        attn_n = (attn_q && !as_clr) || op_done || ((|new_err) && !go_q);
        err_n  = (err_clr ? '0 : err_q) | new_err;
    end

    // read multiplexer
    always_comb begin
        read_val = '0;
        case (int'(rsel))
            ADDR_CTRL: begin
                read_val[CT_AVAIL] = 1'b1;
                read_val[FN_W:1]   = func_q;
                read_val[0]        = go_q;
            end
            ADDR_STAT: begin
                read_val[ST_ATTN]  = attn_q;
                read_val[ST_ERR]   = |err_q;
                read_val[ST_BUSY]  = go_q;
                read_val[ST_READY] = !go_q;
            end
            ADDR_ERR:   read_val = err_q;
            ADDR_MAINT: read_val = maint_q;
            ADDR_ASUM:  read_val[DRIVE_ID] = attn_q;
            default:    read_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            func_q  <= '0;
            attn_q  <= 1'b0;
            err_q   <= '0;
            maint_q <= '0;
            rd_data <= '0;
            rd_oe   <= '0;
        end else begin
            go_q    <= go_n;
            func_q  <= func_n;
            attn_q  <= attn_n;
            err_q   <= err_n;
            maint_q <= maint_n;
            if (access) begin
                rd_data <= is_wr ? '0 : read_val;
                rd_oe   <= is_wr ? '0 :
                           (int'(rsel) == ADDR_ASUM) ? lane_mask : '1;
            end
        end
    end

endmodule

// File: rtl/mdrop_reg_slave.sv
module mdrop_reg_slave
    import mdrop_pkg::*;
#(
    parameter int                   DW         = 16,
    parameter int                   DSEL_W     = 3,
    parameter int                   RSEL_W     = 5,
    parameter int                   FN_W       = 5,
    parameter int                   DRIVE_ID   = 0,
    parameter logic [(2**FN_W)-1:0] LEGAL_MASK = 32'h9190_3D1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DSEL_W-1:0] bus_dsel,
    input  logic [RSEL_W-1:0] bus_rsel,
    input  logic              bus_wr,
    input  logic              bus_dem,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_par,
    output logic [DW-1:0]     bus_dout,
    output logic [DW-1:0]     bus_doe,
    output logic              bus_xfer,
    input  logic              op_done,
    output logic              go,
    output logic [FN_W-1:0]   func,
    output logic              attn,
    output logic [DW-1:0]     err_flags
);

    localparam int LANES = 2 ** DSEL_W;

    logic          hit, access, par_ok;
    logic [DW-1:0] rd_data, rd_oe;

    assign hit    = (int'(bus_rsel) == ADDR_ASUM) || (bus_dsel == DSEL_W'(DRIVE_ID));
    assign par_ok = ^{bus_din, bus_par};

    mdrop_hs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .dem    (bus_dem),
        .hit    (hit),
        .access (access),
        .xfer   (bus_xfer)
    );

    mdrop_regs #(
        .DW(DW), .RSEL_W(RSEL_W), .FN_W(FN_W),
        .DRIVE_ID(DRIVE_ID), .LEGAL_MASK(LEGAL_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (access),
        .is_wr   (bus_wr),
        .rsel    (bus_rsel),
        .wdata   (bus_din),
        .par_ok  (par_ok),
        .op_done (op_done),
        .go_q    (go),
        .func_q  (func),
        .attn_q  (attn),
        .err_q   (err_flags),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    assign bus_dout = bus_xfer ? rd_data : '0;
    assign bus_doe  = bus_xfer ? rd_oe   : '0;

    initial begin
        if (DRIVE_ID >= LANES || LANES > DW)
            $error("mdrop_reg_slave: DRIVE_ID outside summary lanes");
    end

endmodule

// File: rtl/mdrop_reg_slave_chk.sv
module mdrop_reg_slave_chk
    import mdrop_pkg::*;
#(
    parameter int DW       = 16,
    parameter int RSEL_W   = 5,
    parameter int DRIVE_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_dem,
    input logic              bus_wr,
    input logic [RSEL_W-1:0] bus_rsel,
    input logic              bus_xfer,
    input logic [DW-1:0]     bus_doe,
    input logic              go,
    input logic              attn,
    input logic [DW-1:0]     err_flags,
    input logic              op_done
);

    localparam logic [DW-1:0] LANE = DW'(1) << DRIVE_ID;

    // R3
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_xfer && bus_dem) |=> bus_xfer);

    // R3
    xfer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_xfer) |-> bus_dem);

    // R2
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe != '0) |-> (bus_xfer && !bus_wr));

    // R8
    lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_xfer && !bus_wr && int'(bus_rsel) == ADDR_ASUM) |-> (bus_doe == LANE));

    // R6
    refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[EB_RMR]) |-> $past(go));

    // R7
    go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> ($past(bus_wr) && int'($past(bus_rsel)) == ADDR_CTRL));

    // R11
    done_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> attn);

    // R10
    parity_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[EB_CPAR]) |-> $past(bus_wr));

endmodule

bind mdrop_reg_slave mdrop_reg_slave_chk #(
    .DW(DW), .RSEL_W(RSEL_W), .DRIVE_ID(DRIVE_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_dem   (bus_dem),
    .bus_wr    (bus_wr),
    .bus_rsel  (bus_rsel),
    .bus_xfer  (bus_xfer),
    .bus_doe   (bus_doe),
    .go        (go),
    .attn      (attn),
    .err_flags (err_flags),
    .op_done   (op_done)
);

// File: tb/mdrop_reg_slave_test.sv
`timescale 1ns/1ps
module mdrop_reg_slave_test;

    localparam int ID = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_dsel = '0;
    logic [4:0]  bus_rsel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_dem = 1'b0;
    logic [15:0] bus_din = '0;
    logic        bus_par = 1'b0;
    logic [15:0] bus_dout, bus_doe;
    logic        bus_xfer;
    logic        op_done = 1'b0;
    logic        go, attn;
    logic [4:0]  func;
    logic [15:0] err_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the register bank
    bit          m_go, m_attn;
    logic [4:0]  m_func;
    logic [15:0] m_err, m_maint;

    always #2 clk = ~clk;

    mdrop_reg_slave #(.DRIVE_ID(ID)) uut (
        .clk(clk), .rst_n(rst_n), .bus_dsel(bus_dsel), .bus_rsel(bus_rsel),
        .bus_wr(bus_wr), .bus_dem(bus_dem), .bus_din(bus_din), .bus_par(bus_par),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_xfer(bus_xfer),
        .op_done(op_done), .go(go), .func(func), .attn(attn), .err_flags(err_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit legal_fn(input int f);
        return f inside {0, 1, 3, 4, 8, 10, 11, 12, 13, 20, 23, 24, 28, 31};
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] rs);
        logic [15:0] v = '0;
        case (rs)
            5'd0: v = 16'h0800 | (16'(m_func) << 1) | 16'(m_go);
            5'd1: v = (16'(m_attn) << 15) | (16'(m_err != 0) << 14) |
                      (16'(m_go) << 13) | (16'(!m_go) << 7);
            5'd2: v = m_err;
            5'd3: v = m_maint;
            5'd4: v = 16'(m_attn) << ID;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_apply(input bit wr, input logic [4:0] rs,
                               input logic [15:0] d, input bit pg);
        logic [15:0] ne = '0;
        bit go0 = m_go;
        if (wr && !pg) ne[3] = 1'b1;
        if (rs > 5'd4) ne[1] = 1'b1;
        else if (wr && pg) begin
            if (m_go && rs <= 5'd2) ne[2] = 1'b1;
            else case (rs)
                5'd0: begin
                    m_func = d[5:1];
                    if (d[0] && !legal_fn(int'(d[5:1]))) ne[0] = 1'b1;
                    else m_go = d[0];
                end
                5'd2: m_err = '0;
                5'd3: m_maint = d;
                5'd4: if (d[ID]) m_attn = 1'b0;
                default: ;
            endcase
        end
        if (ne != 0 && !go0) m_attn = 1'b1;
        m_err = m_err | ne;
    endtask

    task automatic state_chk(input string tag);
        chk({tag, " go"}, 32'(go), 32'(m_go));
        chk({tag, " attn"}, 32'(attn), 32'(m_attn));
        chk({tag, " err"}, 32'(err_flags), 32'(m_err));
    endtask

    task automatic bus_access(input bit wr, input logic [2:0] ds, input logic [4:0] rs,
                              input logic [15:0] d, input bit pg, input bit abort_it,
                              input string tag);
        bit hit;
        logic [15:0] e_rd, e_oe;
        @(negedge clk);
        bus_wr = wr; bus_dsel = ds; bus_rsel = rs; bus_din = d;
        bus_par = pg ? ~^d : ^d;
        bus_dem = 1'b1;
        hit  = (rs == 5'd4) || (ds == 3'(ID));
        e_rd = wr ? 16'h0 : exp_read(rs);
        e_oe = wr ? 16'h0 : ((rs == 5'd4) ? (16'h1 << ID) : 16'hFFFF);
        @(negedge clk);
        chk("R1 settle cycle no xfer", 32'(bus_xfer), 0);
        if (abort_it) begin
            bus_dem = 1'b0;
            @(negedge clk);
            chk("R3 aborted no xfer", 32'(bus_xfer), 0);
            @(negedge clk);
            chk("R3 aborted no xfer later", 32'(bus_xfer), 0);
            state_chk({tag, " R3 abort"});
            return;
        end
        @(negedge clk);
        chk(hit ? "R1 xfer at second edge" : "R4 unselected no xfer", 32'(bus_xfer), 32'(hit));
        if (hit) begin
            chk("R2 R8 enable", 32'(bus_doe), 32'(e_oe));
            chk("R2 R5 R13 data", 32'(bus_dout & bus_doe), 32'(e_rd & e_oe));
            model_apply(wr, rs, d, pg);
        end
        @(negedge clk);
        chk("R3 xfer held", 32'(bus_xfer), 32'(hit));
        bus_dem = 1'b0;
        @(negedge clk);
        chk("R3 xfer released", 32'(bus_xfer), 0);
        chk("R2 enables off", 32'(bus_doe), 0);
        state_chk(tag);
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        m_go = 1'b0; m_attn = 1'b1;
        chk("R11 done clears go", 32'(go), 0);
        chk("R11 done sets attn", 32'(attn), 1);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        m_go = 0; m_attn = 0; m_func = '0; m_err = '0; m_maint = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset go", 32'(go), 0);
        chk("R13 reset attn", 32'(attn), 0);
        chk("R13 reset err", 32'(err_flags), 0);
        chk("R13 reset xfer", 32'(bus_xfer), 0);
        chk("R13 reset oe", 32'(bus_doe), 0);

        bus_access(0, 3'(ID), 5'd0, 0, 1, 0, "R13 ctrl read");
        bus_access(1, 3'(ID), 5'd3, 16'h1234, 1, 0, "R1 maint write");
        bus_access(0, 3'(ID), 5'd3, 0, 1, 0, "R2 maint read");
        bus_access(1, 3'(ID), 5'd3, 16'hFFFF, 1, 1, "R3 abort write");
        bus_access(0, 3'(ID), 5'd3, 0, 1, 0, "R3 maint after abort");
        chk("R3 maint kept", 32'(m_maint), 32'h1234);
        bus_access(1, 3'd2, 5'd3, 16'hBEEF, 1, 0, "R4 other drive write");
        bus_access(0, 3'(ID), 5'd3, 0, 1, 0, "R4 maint after mismatch");
        bus_access(0, 3'(ID), 5'd6, 0, 1, 0, "R5 missing register");
        chk("R5 ilr bit", 32'(err_flags[1]), 1);
        bus_access(0, 3'd0, 5'd4, 0, 1, 0, "R8 summary read any select");
        bus_access(1, 3'd1, 5'd4, 16'hFFDF, 1, 0, "R9 summary write zero lane");
        chk("R9 zero keeps attn", 32'(attn), 1);
        bus_access(1, 3'd1, 5'd4, 16'h0020, 1, 0, "R9 summary write one");
        chk("R9 one clears attn", 32'(attn), 0);
        bus_access(1, 3'(ID), 5'd2, 0, 1, 0, "R12 clear errors");
        chk("R12 errors cleared", 32'(err_flags), 0);
        bus_access(1, 3'(ID), 5'd0, 16'h0005, 1, 0, "R7 illegal code");
        chk("R7 ilf set", 32'(err_flags[0]), 1);
        chk("R7 go stays clear", 32'(go), 0);
        bus_access(1, 3'(ID), 5'd2, 0, 1, 0, "R12 clear");
        bus_access(1, 3'd7, 5'd4, 16'h0020, 1, 0, "R9 clear");
        bus_access(1, 3'(ID), 5'd0, 16'h0007, 1, 0, "R7 legal code");
        chk("R7 go set", 32'(go), 1);
        bus_access(0, 3'(ID), 5'd1, 0, 1, 0, "R13 status busy");
        bus_access(1, 3'(ID), 5'd3, 16'hABCD, 1, 0, "R6 maint while busy");
        chk("R6 maint accepted", 32'(m_maint), 32'hABCD);
        bus_access(0, 3'(ID), 5'd3, 0, 1, 0, "R6 maint readback");
        bus_access(1, 3'(ID), 5'd0, 16'h0001, 1, 0, "R6 ctrl refused");
        chk("R6 rmr set", 32'(err_flags[2]), 1);
        chk("R6 no attn", 32'(attn), 0);
        bus_access(1, 3'(ID), 5'd2, 0, 1, 0, "R6 err write refused");
        pulse_done();
        bus_access(1, 3'(ID), 5'd3, 16'h5555, 0, 0, "R10 bad parity");
        chk("R10 cpar set", 32'(err_flags[3]), 1);
        chk("R10 write discarded", 32'(m_maint), 32'hABCD);
        bus_access(0, 3'(ID), 5'd3, 0, 1, 0, "R10 maint readback");
        bus_access(0, 3'(ID), 5'd1, 0, 1, 0, "R13 status attn err");

        for (int i = 0; i < 600; i++) begin
            bit wr = 1'($urandom_range(0, 1));
            logic [2:0] ds = ($urandom_range(0, 9) < 5) ? 3'(ID) : 3'($urandom_range(0, 7));
            logic [4:0] rs = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31))
                                                         : 5'($urandom_range(0, 5));
            logic [15:0] d = 16'($urandom);
            bit pg = $urandom_range(0, 19) != 0;
            bit ab = $urandom_range(0, 24) == 0;
            if (rs == 5'd0 && $urandom_range(0, 1) == 1) d[0] = 1'b1;
            if (rs == 5'd4 && $urandom_range(0, 1) == 1) d[ID] = 1'b1;
            bus_access(wr, ds, rs, d, pg, ab, "R11 random state");
            if (m_go && $urandom_range(0, 3) == 0) pulse_done();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule